// File: doc/BRIEF.md
# Mask and Edge Trigger Unit

This block watches a stream of 16-bit samples and raises a trigger flag once a configured condition holds on a sample. When the flag rises, the block stores the capture position of that sample: the number of valid samples seen since the unit was armed. The flag stays set until software arms the unit again.

The condition has two parts, and both must hold. The first is a value/mask test. It is built from four 16-bit lookup tables, one for each group of four channels. Each table is indexed by that group's nibble of the sample. The second part is an edge test. Up to two single-channel detectors, each set for a rising or a falling transition, are ORed together.

Software programs the tables and the edge detectors through a small write port. It reads the status and the 24-bit position through a byte-wide read port. The position is read as three bytes, least significant first.

Top module: `trig_unit`

## Requirements
- R1: After reset the unit is not armed, the fired flag is 0, the position is 0, every lookup table holds 16'hFFFF, both edge detectors are disabled and the remembered previous sample is 0.
- R2: A valid sample passes the value/mask test when, for every quad q, bit n of table q is 1, where n is sample bits [4q+3:4q]. A table built so that bit n is set exactly when (n AND mask nibble) equals the value nibble therefore implements (sample AND mask) == value.
- R3: A write to address 1 selects a table with cfg_wdata[1:0]. A write to address 2 loads cfg_wdata[15:0] into the selected table. The new contents apply from the next cycle.
- R4: A write to address 3 configures edge detector 0, and a write to address 4 configures edge detector 1. The field layout is: cfg_wdata[3:0] channel, bit 8 enable, bit 9 direction (1 = rising, previous bit 0 and current bit 1; 0 = falling, the reverse).
- R5: The results of the enabled edge detectors are ORed. When no detector is enabled, the edge part counts as true. The trigger condition is the AND of the edge part and the value/mask part.
- R6: Writing address 0 with cfg_wdata[0]=1 arms the unit, clears the fired flag and zeroes the sample counter. The first valid sample after the arm write has position 0.
- R7: Only the first matching sample after arming sets the fired flag and the position. Later matches change neither until the unit is armed again.
- R8: While the unit is not armed, or while smp_valid is 0, nothing fires and the sample counter does not advance.
- R9: The fired output and trig_pos change on the clock edge that accepts the triggering sample. rd_data is combinational from rd_addr: address 0 gives bit 5 = fired and bit 0 = armed, and addresses 8, 9 and 10 give position bits [7:0], [15:8] and [23:16].
- R10: Edge detection compares against the most recent valid sample. Cycles with smp_valid low do not replace it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 16 | Sample, one bit per channel |
| fired | output | 1 | Trigger has fired since the last arm |
| trig_pos | output | 24 | Position of the triggering sample |

## Verification
Fired and trig_pos are due one clock edge after the triggering sample is presented. Configuration writes take effect on the sample that follows the write's edge, and rd_data is valid in the same cycle as rd_addr. The bench drives every input at the falling edge. A behavioural model advances at each rising edge, and fired and trig_pos are compared against it at the next falling edge. Each scenario also checks a literal expected position through the read port, which confirms the byte order and the count of samples since the arm write.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_LUTSEL = 4'd1;
    localparam logic [3:0] A_LUTDAT = 4'd2;
    localparam logic [3:0] A_EDGE0  = 4'd3;
    localparam logic [3:0] A_POS0   = 4'd8;
    localparam logic [3:0] A_POS1   = 4'd9;
    localparam logic [3:0] A_POS2   = 4'd10;
    localparam int EDGE_EN_BIT   = 8;
    localparam int EDGE_RISE_BIT = 9;
    localparam int STAT_FIRED_BIT = 5;
endpackage

// File: rtl/trig_quad_lut.sv
module trig_quad_lut #(
    parameter int QW = 4
) (
    input  logic [(1<<QW)-1:0] table_i,
    input  logic [QW-1:0]      nib_i,
    output logic               match_o
);
    always_comb match_o = table_i[nib_i];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int N_CH = 16,
    localparam int SEL_W = $clog2(N_CH)
) (
    input  logic             en_i,
    input  logic             rise_i,
    input  logic [SEL_W-1:0] ch_i,
    input  logic [N_CH-1:0]  cur_i,
    input  logic [N_CH-1:0]  prev_i,
    output logic             hit_o
);
    logic now_b, old_b;
    always_comb begin
        now_b = cur_i[ch_i];
        old_b = prev_i[ch_i];
        if (rise_i) hit_o = en_i && !old_b && now_b;
        else        hit_o = en_i && old_b && !now_b;
    end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import trig_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int N_EDGE = 2,
    parameter int POS_W  = 24,
    localparam int NQ     = N_CH / 4,
    localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int SEL_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [15:0]      cfg_wdata,
    input  logic [3:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             smp_valid,
    input  logic [N_CH-1:0]  smp_data,
    output logic             fired,
    output logic [POS_W-1:0] trig_pos
);
    typedef struct packed {
        logic [NQ-1:0][15:0]         lut;
        logic [QSEL_W-1:0]           lut_sel;
        logic [N_EDGE-1:0]           e_en;
        logic [N_EDGE-1:0]           e_rise;
        logic [N_EDGE-1:0][SEL_W-1:0] e_ch;
        logic [N_CH-1:0]             prev;
        logic                        armed;
        logic                        fired;
        logic [POS_W-1:0]            cnt;
        logic [POS_W-1:0]            pos;
    } st_t;

    st_t q, d;
    logic [NQ-1:0]     qmatch;
    logic [N_EDGE-1:0] ehit;
    logic              mask_ok, edge_ok, hit, arm_wr;

    for (genvar g = 0; g < NQ; g++) begin : g_quad
        trig_quad_lut #(.QW(4)) u_lut (
            .table_i (q.lut[g]),
            .nib_i   (smp_data[4*g +: 4]),
            .match_o (qmatch[g])
        );
    end

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        trig_edge_det #(.N_CH(N_CH)) u_edge (
            .en_i   (q.e_en[e]),
            .rise_i (q.e_rise[e]),
            .ch_i   (q.e_ch[e]),
            .cur_i  (smp_data),
            .prev_i (q.prev),
            .hit_o  (ehit[e])
        );
    end

    always_comb begin
        mask_ok = &qmatch;
        edge_ok = (|q.e_en) ? (|ehit) : 1'b1;
        hit     = mask_ok && edge_ok;
        arm_wr  = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0];
    end

    always_comb begin
        d = q;
        if (cfg_we) begin
            if (cfg_addr == A_LUTSEL) d.lut_sel = cfg_wdata[QSEL_W-1:0];
            if (cfg_addr == A_LUTDAT) d.lut[q.lut_sel] = cfg_wdata;
            for (int e = 0; e < N_EDGE; e++) begin
                if (cfg_addr == A_EDGE0 + 4'(e)) begin
                    d.e_ch[e]   = cfg_wdata[SEL_W-1:0];
                    d.e_en[e]   = cfg_wdata[EDGE_EN_BIT];
                    d.e_rise[e] = cfg_wdata[EDGE_RISE_BIT];
                end
            end
        end
        if (smp_valid) d.prev = smp_data;
        if (arm_wr) begin
            d.armed = 1'b1;
            d.fired = 1'b0;
            d.cnt   = '0;
        end else if (q.armed && smp_valid) begin
            d.cnt = q.cnt + 1'b1;
            if (!q.fired && hit) begin
                d.fired = 1'b1;
                d.pos   = q.cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.lut     <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        fired    = q.fired;
        trig_pos = q.pos;
        rd_data  = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[STAT_FIRED_BIT] = q.fired;
                rd_data[0]              = q.armed;
            end
            A_POS0: rd_data = q.pos[7:0];
            A_POS1: rd_data = q.pos[15:8];
            A_POS2: rd_data = q.pos[23:16];
            default: rd_data = '0;
        endcase
    end

    AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.fired && !arm_wr |=> q.fired);                                  // R7
    AST_POS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        q.fired && !arm_wr |=> $stable(q.pos));                           // R7
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> !q.fired && q.armed && q.cnt == '0);                   // R6
    AST_FIRE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fired) |-> $past(smp_valid) && $past(q.armed));           // R8
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid && !arm_wr |=> $stable(q.cnt));                        // R8
    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(q.prev));                                  // R10
endmodule

// File: tb/tb_trig_unit.sv
module tb_trig_unit;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_addr = 0, rd_addr = 0;
    logic [15:0] cfg_wdata = 0, smp_data = 0;
    logic        smp_valid = 0;
    logic [7:0]  rd_data;
    logic        fired;
    logic [23:0] trig_pos;

    int n_tests = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    trig_unit dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .smp_valid(smp_valid), .smp_data(smp_data), .fired(fired), .trig_pos(trig_pos));

    always #4 clk = ~clk;

    // behavioural reference
    logic [15:0] m_lut [4];
    bit          m_en [2], m_rise [2];
    int          m_ch [2];
    int          m_sel;
    logic [15:0] m_prev;
    bit          m_armed, m_fired;
    int          m_cnt, m_pos;

    function automatic bit m_hit(logic [15:0] s);
        bit mk = 1, any = 0, eh = 0;
        for (int k = 0; k < 4; k++) if (!m_lut[k][(s >> (4*k)) & 15]) mk = 0;
        for (int e = 0; e < 2; e++) if (m_en[e]) begin
            any = 1;
            if (m_rise[e] && !m_prev[m_ch[e]] && s[m_ch[e]]) eh = 1;
            if (!m_rise[e] && m_prev[m_ch[e]] && !s[m_ch[e]]) eh = 1;
        end
        return mk && (any ? eh : 1'b1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) m_lut[k] = 16'hFFFF;
            for (int e = 0; e < 2; e++) begin m_en[e] = 0; m_rise[e] = 0; m_ch[e] = 0; end
            m_sel = 0; m_prev = 0; m_armed = 0; m_fired = 0; m_cnt = 0; m_pos = 0;
        end else begin
            bit h;
            h = m_hit(smp_data);
            if (cfg_we) begin
                if (cfg_addr == 1) m_sel = cfg_wdata & 3;
                if (cfg_addr == 2) m_lut[m_sel] = cfg_wdata;
                if (cfg_addr == 3 || cfg_addr == 4) begin
                    m_ch[cfg_addr-3]   = cfg_wdata & 15;
                    m_en[cfg_addr-3]   = cfg_wdata[8];
                    m_rise[cfg_addr-3] = cfg_wdata[9];
                end
            end
            if (cfg_we && cfg_addr == 0 && cfg_wdata[0]) begin
                m_armed = 1; m_fired = 0; m_cnt = 0;
            end else if (m_armed && smp_valid) begin
                if (!m_fired && h) begin m_fired = 1; m_pos = m_cnt; end
                m_cnt = (m_cnt + 1) & 24'hFFFFFF;
            end
            if (smp_valid) m_prev = smp_data;
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // R9 / R7: outputs against the model every cycle
    always @(negedge clk) if (rst_n && !done) begin
        chk("R9 cycle fired", int'(fired), int'(m_fired));
        chk("R7 cycle pos", int'(trig_pos), m_pos);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] v);
        cfg_we = 1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    endtask

    task automatic smp(logic [15:0] v, bit vld = 1);
        smp_valid = vld; smp_data = v;
        @(negedge clk);
        smp_valid = 0; smp_data = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic rd_pos(output int p);
        logic [7:0] b0, b1, b2;
        rd(8, b0); rd(9, b1); rd(10, b2);
        p = {b2, b1, b0};
    endtask

    function automatic logic [15:0] lut_for(logic [3:0] v, logic [3:0] m);
        logic [15:0] t = 0;
        for (int n = 0; n < 16; n++) if ((n[3:0] & m) == (v & m)) t[n] = 1;
        return t;
    endfunction

    task automatic load_mask(logic [15:0] v, logic [15:0] m);
        for (int k = 0; k < 4; k++) begin
            wr(1, 16'(k));
            wr(2, lut_for(v[4*k +: 4], m[4*k +: 4]));
        end
    endtask

    initial begin
        logic [7:0] s;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(0, s); chk("R1 status after reset", s, 0);
        rd_pos(p); chk("R1 position after reset", p, 0);
        chk("R1 fired after reset", fired, 0);
        // R8 unarmed: all-ones tables would match, but no fire
        smp(16'h1234); smp(16'h0000);
        chk("R8 unarmed no fire", fired, 0);
        // R6/R8: arm, idle cycles do not count, first valid is position 0
        wr(0, 16'h0001);
        rd(0, s); chk("R6 armed status", s, 8'h01);
        smp(16'hFFFF, 0); smp(16'h5555, 0);
        chk("R8 invalid no fire", fired, 0);
        smp(16'h0042);
        chk("R1 default tables match", fired, 1);
        rd_pos(p); chk("R6 first valid is pos 0", p, 0);
        rd(0, s); chk("R9 status fired+armed", s, 8'h21);

        // R2/R3 value/mask: mask F00F value A003
        load_mask(16'hA003, 16'hF00F);
        wr(0, 16'h0001);
        rd(0, s); chk("R6 rearm clears fired", s, 8'h01);
        smp(16'h0000); smp(16'h1234); smp(16'hA002); smp(16'hB003); smp(16'h0A03);
        chk("R2 no match yet", fired, 0);
        smp(16'hA7F3);
        chk("R2 match fires", fired, 1);
        rd_pos(p); chk("R2 match position", p, 5);
        smp(16'hA003); smp(16'hA553);
        rd_pos(p); chk("R7 later match ignored", p, 5);

        // R4/R5 rising on ch3, tables all ones
        load_mask(16'h0000, 16'h0000);
        wr(3, 16'h0303);
        smp(16'h0008);
        wr(0, 16'h0001);
        smp(16'h0008); smp(16'h0000);
        chk("R4 no rise yet", fired, 0);
        smp(16'h0008);
        chk("R4 rising fires", fired, 1);
        rd_pos(p); chk("R4 rising position", p, 2);

        // R5 second detector falling on ch9, ORed
        wr(4, 16'h0109);
        wr(0, 16'h0001);
        smp(16'h0208);
        chk("R5 no edge on rise of ch9", fired, 0);
        smp(16'h0008);
        rd_pos(p); chk("R5 falling via OR", p, 1);

        // R5 AND with quad2 nibble == 5
        wr(1, 16'h0002); wr(2, 16'h0020);
        wr(0, 16'h0001);
        smp(16'h0000); smp(16'h0008); smp(16'h0500);
        chk("R5 edge without mask no fire", fired, 0);
        smp(16'h0508);
        rd_pos(p); chk("R5 edge and mask", p, 3);

        // R10 previous sample kept across invalid cycles
        wr(2, 16'hFFFF); wr(4, 16'h0000);
        wr(0, 16'h0001);
        smp(16'h0008); smp(16'h0000, 0); smp(16'h0008);
        chk("R10 invalid low not used as prev", fired, 0);
        smp(16'h0000); smp(16'h0008, 0); smp(16'h0008);
        chk("R10 rise vs last valid", fired, 1);
        rd_pos(p); chk("R10 position", p, 3);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule